// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is the register file and command sequencer of a bus endpoint that exists only to exercise a host. Software on the host reaches it through a small word-addressed register port. The host programs a source address, a destination address and a byte count, then writes a command word. The engine then moves data word by word through a request/acknowledge memory master port into or out of host buffers.

Three operations are available. A read fetches words from the source buffer and discards them. A write fills the destination buffer with an incrementing pattern. A copy moves words from the source buffer to the destination buffer. Every word moved is folded into a 32-bit XOR checksum. Each operation ends with a success or fail flag in the status register. When the command asks for it, the engine also sends a one-cycle legacy interrupt or message interrupt together with a vector number. Address validity, size validity and command priority are all checked before any memory traffic starts.

Top module: `eptest_engine`

## Requirements
- R1: The scratch register at byte offset 0x00 stores any 32-bit value written to it and returns that value on read.
- R2: Byte offsets are: 0x04 command (11 bits), 0x08 status (9 bits), 0x0C source address, 0x10 destination address, 0x14 size in bytes, 0x18 checksum. All read as zero after reset. Writes to status and checksum are ignored. Any other offset reads zero.
- R3: Command bits: 0 = legacy interrupt, 1 = message interrupt, 7:2 = vector, 8 = read, 9 = write, 10 = copy. A command write while idle clears the status register and starts the command. A command write while a command runs is ignored. The command register reads zero once the command completes.
- R4: A read fetches size/4 words from ascending word addresses starting at the source address. The checksum becomes the XOR of the fetched words, and on success status bit 0 is set.
- R5: A write stores the values 0, 1, 2, ... into size/4 ascending words starting at the destination address. The checksum becomes the XOR of those values, and status bit 2 is set.
- R6: A copy moves size/4 words from the source buffer to the destination buffer, one read then one write per word. The checksum is the XOR of the moved words, and status bit 4 is set.
- R7: An address is invalid when it is zero or when its two low bits are not both zero. An invalid source on a read or copy sets status bit 7. An invalid destination on a write or copy sets status bit 8. In both cases the fail bit of the operation is set (bit 1 read, bit 3 write, bit 5 copy) and no memory access is made.
- R8: A size that is zero or not a multiple of 4 sets only the fail bit of the operation and makes no memory access.
- R9: When more than one operation bit is set, read wins over write and write wins over copy. Only the winning operation runs.
- R10: On completion, with command bit 0 or bit 1 set, the matching interrupt output is high for exactly one cycle, the vector output carries command bits 7:2 in that cycle (zero otherwise), and status bit 6 is set. With neither bit set, no interrupt is raised and bit 6 stays clear.
- R11: The memory request stays asserted, with address and direction unchanged, until acknowledged. Every request address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; accepts the request in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| irq_legacy | output | 1 | One-cycle legacy interrupt pulse |
| irq_msg | output | 1 | One-cycle message interrupt request |
| irq_vec | output | 6 | Interrupt vector during a pulse, zero otherwise |

## Verification
Register reads are combinational, so the bench samples a register half a cycle after it sets the offset. A command rejected by the validity checks takes a fixed two edges after the command-write edge. The first edge records the invalid-address bits and schedules completion. In the cycle after that edge the interrupt pulse and vector are due, and after the second edge the fail bit is due and the command register reads zero. The bench checks this path at those exact falling edges. Transfers last a number of cycles that depends on memory latency, so the bench polls the command register until it reads zero and only then compares status, checksum, buffer contents and the count of memory accesses.

// File: rtl/eptest_pkg.sv
package eptest_pkg;
  localparam int DW     = 32;
  localparam int RAW    = 5;
  localparam int CMD_W  = 11;
  localparam int STAT_W = 9;
  localparam int VEC_W  = 6;

  localparam logic [RAW-1:0] OFS_MAGIC = 5'h00;
  localparam logic [RAW-1:0] OFS_CMD   = 5'h04;
  localparam logic [RAW-1:0] OFS_STAT  = 5'h08;
  localparam logic [RAW-1:0] OFS_SRC   = 5'h0C;
  localparam logic [RAW-1:0] OFS_DST   = 5'h10;
  localparam logic [RAW-1:0] OFS_SIZE  = 5'h14;
  localparam logic [RAW-1:0] OFS_CSUM  = 5'h18;

  localparam int C_LEG = 0;
  localparam int C_MSG = 1;
  localparam int C_VLO = 2;
  localparam int C_RD  = 8;
  localparam int C_WR  = 9;
  localparam int C_CP  = 10;

  localparam int S_RD_OK   = 0;
  localparam int S_RD_FAIL = 1;
  localparam int S_WR_OK   = 2;
  localparam int S_WR_FAIL = 3;
  localparam int S_CP_OK   = 4;
  localparam int S_CP_FAIL = 5;
  localparam int S_IRQ     = 6;
  localparam int S_BAD_SRC = 7;
  localparam int S_BAD_DST = 8;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR, OP_CP} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_RD, ST_WR, ST_DONE} st_e;
endpackage

// File: rtl/eptest_regs.sv
module eptest_regs
  import eptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [STAT_W-1:0] stat_set,
  input  logic [DW-1:0]     csum,
  output logic              start,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [STAT_W-1:0] status_q,
  output logic [DW-1:0]     src_q,
  output logic [DW-1:0]     dst_q,
  output logic [DW-1:0]     size_q
);
  logic [DW-1:0]     magic_q;
  logic [CMD_W-1:0]  cmd_d;
  logic [STAT_W-1:0] status_d;
  logic              magic_we, src_we, dst_we, size_we;

  assign magic_we = reg_we && (reg_addr == OFS_MAGIC);
  assign src_we   = reg_we && (reg_addr == OFS_SRC);
  assign dst_we   = reg_we && (reg_addr == OFS_DST);
  assign size_we  = reg_we && (reg_addr == OFS_SIZE);
  assign start    = reg_we && (reg_addr == OFS_CMD) && !busy;

  always_comb begin
    cmd_d    = cmd_q;
    status_d = status_q | stat_set;
    if (start) begin
      cmd_d    = reg_wdata[CMD_W-1:0];
      status_d = '0;
    end else if (done) begin
      cmd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      magic_q  <= '0;
      cmd_q    <= '0;
      status_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      size_q   <= '0;
    end else begin
      if (magic_we) magic_q <= reg_wdata;
      if (src_we)   src_q   <= reg_wdata;
      if (dst_we)   dst_q   <= reg_wdata;
      if (size_we)  size_q  <= reg_wdata;
      cmd_q    <= cmd_d;
      status_q <= status_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MAGIC: reg_rdata = magic_q;
      OFS_CMD:   reg_rdata = {{(DW-CMD_W){1'b0}}, cmd_q};
      OFS_STAT:  reg_rdata = {{(DW-STAT_W){1'b0}}, status_q};
      OFS_SRC:   reg_rdata = src_q;
      OFS_DST:   reg_rdata = dst_q;
      OFS_SIZE:  reg_rdata = size_q;
      OFS_CSUM:  reg_rdata = csum;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eptest_seq.sv
module eptest_seq
  import eptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DW-1:0]     src,
  input  logic [DW-1:0]     dst,
  input  logic [DW-1:0]     size,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] stat_set,
  output logic [DW-1:0]     csum,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq_legacy,
  output logic              irq_msg,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam int IW = DW - 2;

  st_e           state_q, state_d;
  op_e           op_q, op_d, op_sel;
  logic [IW-1:0] idx_q, idx_d, last_q, last_d;
  logic          ok_q, ok_d, ok_chk;
  logic [DW-1:0] csum_q, csum_d, dbuf_q, dbuf_d;
  logic [DW-1:0] sbase_q, sbase_d, dbase_q, dbase_d;
  logic          need_src, need_dst, src_ok, dst_ok, size_ok, at_last;
  logic [DW-1:0] pattern;

  always_comb begin
    if (cmd[C_RD])      op_sel = OP_RD;
    else if (cmd[C_WR]) op_sel = OP_WR;
    else if (cmd[C_CP]) op_sel = OP_CP;
    else                op_sel = OP_NONE;
  end

  assign need_src = (op_sel == OP_RD) || (op_sel == OP_CP);
  assign need_dst = (op_sel == OP_WR) || (op_sel == OP_CP);
  assign src_ok   = (src != '0) && (src[1:0] == 2'b00);
  assign dst_ok   = (dst != '0) && (dst[1:0] == 2'b00);
  assign size_ok  = (size != '0) && (size[1:0] == 2'b00);
  assign ok_chk   = (!need_src || src_ok) && (!need_dst || dst_ok) && size_ok;
  assign at_last  = (idx_q == last_q);
  assign pattern  = {2'b00, idx_q};

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    idx_d    = idx_q;
    last_d   = last_q;
    ok_d     = ok_q;
    csum_d   = csum_q;
    dbuf_d   = dbuf_q;
    sbase_d  = sbase_q;
    dbase_d  = dbase_q;
    stat_set = '0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_CHECK;
      ST_CHECK: begin
        op_d    = op_sel;
        idx_d   = '0;
        csum_d  = '0;
        sbase_d = src;
        dbase_d = dst;
        last_d  = size[DW-1:2] - 1'b1;
        ok_d    = ok_chk;
        stat_set[S_BAD_SRC] = need_src && !src_ok;
        stat_set[S_BAD_DST] = need_dst && !dst_ok;
        if (op_sel == OP_NONE || !ok_chk) state_d = ST_DONE;
        else if (op_sel == OP_WR)         state_d = ST_WR;
        else                              state_d = ST_RD;
      end
      ST_RD: if (mem_ack) begin
        csum_d = csum_q ^ mem_rdata;
        dbuf_d = mem_rdata;
        if (op_q == OP_CP) state_d = ST_WR;
        else begin
          idx_d = idx_q + 1'b1;
          if (at_last) state_d = ST_DONE;
        end
      end
      ST_WR: if (mem_ack) begin
        if (op_q == OP_WR) csum_d = csum_q ^ pattern;
        idx_d = idx_q + 1'b1;
        if (at_last)            state_d = ST_DONE;
        else if (op_q == OP_CP) state_d = ST_RD;
      end
      ST_DONE: begin
        stat_set[S_RD_OK]   = (op_q == OP_RD) && ok_q;
        stat_set[S_RD_FAIL] = (op_q == OP_RD) && !ok_q;
        stat_set[S_WR_OK]   = (op_q == OP_WR) && ok_q;
        stat_set[S_WR_FAIL] = (op_q == OP_WR) && !ok_q;
        stat_set[S_CP_OK]   = (op_q == OP_CP) && ok_q;
        stat_set[S_CP_FAIL] = (op_q == OP_CP) && !ok_q;
        stat_set[S_IRQ]     = cmd[C_LEG] || cmd[C_MSG];
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      idx_q   <= '0;
      last_q  <= '0;
      ok_q    <= 1'b0;
      csum_q  <= '0;
      dbuf_q  <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      ok_q    <= ok_d;
      csum_q  <= csum_d;
      dbuf_q  <= dbuf_d;
      sbase_q <= sbase_d;
      dbase_q <= dbase_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign csum       = csum_q;
  assign mem_req    = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we     = (state_q == ST_WR);
  assign mem_addr   = ((state_q == ST_RD) ? sbase_q : dbase_q) + {idx_q, 2'b00};
  assign mem_wdata  = (op_q == OP_WR) ? pattern : dbuf_q;
  assign irq_legacy = done && cmd[C_LEG];
  assign irq_msg    = done && cmd[C_MSG];
  assign irq_vec    = (irq_legacy || irq_msg) ? cmd[C_VLO +: VEC_W] : '0;
endmodule

// File: rtl/eptest_engine.sv
module eptest_engine
  import eptest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             irq_legacy,
  output logic             irq_msg,
  output logic [VEC_W-1:0] irq_vec
);
  logic              rst_meta, rst_sync_n;
  logic              start, busy, done;
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] status_q, stat_set;
  logic [DW-1:0]     src_q, dst_q, size_q, csum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  eptest_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .stat_set(stat_set), .csum(csum),
    .start(start), .cmd_q(cmd_q), .status_q(status_q),
    .src_q(src_q), .dst_q(dst_q), .size_q(size_q)
  );

  eptest_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start(start), .cmd(cmd_q), .src(src_q), .dst(dst_q), .size(size_q),
    .busy(busy), .done(done), .stat_set(stat_set), .csum(csum),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq_legacy(irq_legacy), .irq_msg(irq_msg), .irq_vec(irq_vec)
  );
endmodule

// File: rtl/eptest_chk.sv
module eptest_chk
  import eptest_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DW-1:0]     mem_addr,
  input logic              mem_ack,
  input logic              irq_legacy,
  input logic              irq_msg,
  input logic [STAT_W-1:0] status
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R11
  AST_LEGACY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_legacy |=> !irq_legacy); // R10
  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg |=> !irq_msg); // R10
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_legacy || irq_msg) |=> status[S_IRQ]); // R10
  AST_BAD_SRC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[S_BAD_SRC]) |=> (status[S_RD_FAIL] || status[S_CP_FAIL])); // R7
  AST_BAD_DST_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[S_BAD_DST]) |=> (status[S_WR_FAIL] || status[S_CP_FAIL])); // R7
  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[S_RD_OK] && status[S_RD_FAIL])); // R4
  AST_ONE_OP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[S_CP_FAIL:S_RD_OK]) <= 1); // R9
endmodule

bind eptest_engine eptest_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .irq_legacy(irq_legacy), .irq_msg(irq_msg), .status(status_q)
);

// File: tb/test_eptest_engine.sv
module test_eptest_engine;
  localparam logic [31:0] BASE = 32'h400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_legacy, irq_msg;
  logic [5:0]  irq_vec;

  int nvec = 0, nbad = 0, acc_cnt = 0, addr_err = 0;
  int leg_cnt = 0, msg_cnt = 0, width_err = 0;
  logic [5:0]  seen_vec;
  logic        leg_prev, msg_prev;
  logic [31:0] mem [64];

  always #10 clk = ~clk;

  eptest_engine i_eptest_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq_legacy(irq_legacy), .irq_msg(irq_msg), .irq_vec(irq_vec)
  );

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h01010101) ^ 32'h9E3779B9;
  endfunction

  always @(posedge clk) begin : memmodel
    int off;
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
    end else if (mem_req && !mem_ack) begin
      off = int'((mem_addr - BASE) >> 2) & 63;
      if (mem_addr < BASE || mem_addr >= BASE + 256 || mem_addr[1:0] != 2'b00)
        addr_err <= addr_err + 1;
      mem_ack <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[off] <= mem_wdata;
      else        mem_rdata <= mem[off];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      leg_prev <= 1'b0;
      msg_prev <= 1'b0;
      seen_vec <= '0;
    end else begin
      if (irq_legacy) leg_cnt <= leg_cnt + 1;
      if (irq_msg)    msg_cnt <= msg_cnt + 1;
      if (irq_legacy || irq_msg) seen_vec <= irq_vec;
      if ((irq_legacy && leg_prev) || (irq_msg && msg_prev)) width_err <= width_err + 1;
      leg_prev <= irq_legacy;
      msg_prev <= irq_msg;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input logic [31:0] cmd, output logic [31:0] st);
    logic [31:0] c;
    wr(5'h04, cmd);
    for (int k = 0; k < 2000; k++) begin
      rd(5'h04, c);
      if (c == 0) break;
    end
    @(negedge clk);
    rd(5'h08, st);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d, st, x;
    int a0, l0, m0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int o = 0; o <= 6; o++) begin
      rd(5'(o * 4), d);
      chk("R2 reset value", d, 32'h0);
    end
    chk("R11 reset req", {31'b0, mem_req}, 32'h0);
    chk("R10 reset irq", {30'b0, irq_legacy, irq_msg}, 32'h0);

    foreach (x[i]) begin end
    for (int p = 0; p < 6; p++) begin
      x = (p == 5) ? 32'h0 : (32'hA5A5_5A5A << p) ^ (32'h1 << (p * 7));
      wr(5'h00, x);
      rd(5'h00, d);
      chk("R1 scratch", d, x);
    end

    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk("R2 status read-only", d, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, d); chk("R2 checksum read-only", d, 32'h0);
    rd(5'h1C, d); chk("R2 unmapped offset", d, 32'h0);
    wr(5'h0C, 32'h0000_0404); rd(5'h0C, d); chk("R2 source reg", d, 32'h404);
    wr(5'h10, 32'h0000_0408); rd(5'h10, d); chk("R2 destination reg", d, 32'h408);
    wr(5'h14, 32'h0000_0010); rd(5'h14, d); chk("R2 size reg", d, 32'h10);

    // R4 read sweep
    for (int b = 0; b < 2; b++) begin
      for (int n = 1; n <= 8; n++) begin
        wr(5'h0C, BASE + 32'(b * 20));
        wr(5'h14, 32'(n * 4));
        a0 = acc_cnt;
        run(32'h100, st);
        chk("R4 read status", st, 32'h001);
        x = '0;
        for (int k = 0; k < n; k++) x ^= init_word(b * 5 + k);
        rd(5'h18, d); chk("R4 read checksum", d, x);
        chk("R4 read access count", 32'(acc_cnt - a0), 32'(n));
      end
    end

    // R5 write sweep
    for (int n = 1; n <= 8; n++) begin
      wr(5'h10, BASE + 32'(20 * 4));
      wr(5'h14, 32'(n * 4));
      run(32'h200, st);
      chk("R5 write status", st, 32'h004);
      x = '0;
      for (int k = 0; k < n; k++) begin
        x ^= 32'(k);
        chk("R5 write data", mem[20 + k], 32'(k));
      end
      chk("R5 word past end untouched", mem[20 + n], init_word(20 + n));
      rd(5'h18, d); chk("R5 write checksum", d, x);
    end

    // R6 copy sweep
    for (int n = 1; n <= 6; n++) begin
      wr(5'h0C, BASE);
      wr(5'h10, BASE + 32'(40 * 4));
      wr(5'h14, 32'(n * 4));
      a0 = acc_cnt;
      run(32'h400, st);
      chk("R6 copy status", st, 32'h010);
      x = '0;
      for (int k = 0; k < n; k++) begin
        x ^= init_word(k);
        chk("R6 copy data", mem[40 + k], init_word(k));
      end
      rd(5'h18, d); chk("R6 copy checksum", d, x);
      chk("R6 copy access count", 32'(acc_cnt - a0), 32'(2 * n));
    end

    // R7 invalid addresses
    wr(5'h14, 32'h8);
    for (int c = 0; c < 7; c++) begin
      logic [31:0] s, t, cm, ex;
      case (c)
        0: begin s = 32'h0;      t = BASE;       cm = 32'h100; ex = 32'h082; end
        1: begin s = BASE + 2;   t = BASE;       cm = 32'h100; ex = 32'h082; end
        2: begin s = BASE;       t = 32'h0;      cm = 32'h200; ex = 32'h108; end
        3: begin s = BASE;       t = BASE + 1;   cm = 32'h200; ex = 32'h108; end
        4: begin s = BASE + 3;   t = BASE;       cm = 32'h400; ex = 32'h0A0; end
        5: begin s = BASE;       t = 32'h0;      cm = 32'h400; ex = 32'h120; end
        default: begin s = 32'h0; t = BASE + 2;  cm = 32'h400; ex = 32'h1A0; end
      endcase
      wr(5'h0C, s); wr(5'h10, t);
      a0 = acc_cnt;
      run(cm, st);
      chk("R7 invalid address status", st, ex);
      chk("R7 no access", 32'(acc_cnt - a0), 32'h0);
    end

    // R8 invalid sizes
    wr(5'h0C, BASE); wr(5'h10, BASE + 32'h80);
    for (int c = 0; c < 5; c++) begin
      logic [31:0] sz, cm, ex;
      case (c)
        0: begin sz = 32'h0; cm = 32'h100; ex = 32'h002; end
        1: begin sz = 32'h6; cm = 32'h100; ex = 32'h002; end
        2: begin sz = 32'h2; cm = 32'h100; ex = 32'h002; end
        3: begin sz = 32'h0; cm = 32'h200; ex = 32'h008; end
        default: begin sz = 32'h3; cm = 32'h400; ex = 32'h020; end
      endcase
      wr(5'h14, sz);
      a0 = acc_cnt;
      run(cm, st);
      chk("R8 bad size status", st, ex);
      chk("R8 no access", 32'(acc_cnt - a0), 32'h0);
    end

    // R9 priority
    wr(5'h14, 32'h8);
    a0 = acc_cnt; run(32'h700, st);
    chk("R9 read over write and copy", st, 32'h001);
    chk("R9 only read traffic", 32'(acc_cnt - a0), 32'h2);
    a0 = acc_cnt; run(32'h600, st);
    chk("R9 write over copy", st, 32'h004);
    chk("R9 only write traffic", 32'(acc_cnt - a0), 32'h2);
    run(32'h500, st);
    chk("R9 read over copy", st, 32'h001);

    // R10 interrupts
    for (int v = 0; v < 64; v += 21) begin
      l0 = leg_cnt; m0 = msg_cnt;
      run(32'h100 | 32'(v << 2) | 32'h1, st);
      chk("R10 legacy status", st, 32'h041);
      chk("R10 legacy pulses", 32'(leg_cnt - l0), 32'h1);
      chk("R10 legacy no msg", 32'(msg_cnt - m0), 32'h0);
      chk("R10 legacy vector", {26'b0, seen_vec}, 32'(v));
      l0 = leg_cnt; m0 = msg_cnt;
      run(32'h200 | 32'(v << 2) | 32'h2, st);
      chk("R10 msg status", st, 32'h044);
      chk("R10 msg pulses", 32'(msg_cnt - m0), 32'h1);
      chk("R10 msg no legacy", 32'(leg_cnt - l0), 32'h0);
      chk("R10 msg vector", {26'b0, seen_vec}, 32'(v));
    end
    l0 = leg_cnt; m0 = msg_cnt;
    run(32'h3 | (32'd5 << 2), st);
    chk("R10 both requests status", st, 32'h040);
    chk("R10 both pulses", 32'(leg_cnt - l0 + msg_cnt - m0), 32'h2);
    l0 = leg_cnt; m0 = msg_cnt;
    run(32'h100, st);
    chk("R10 no request status", st, 32'h001);
    chk("R10 no request pulses", 32'(leg_cnt - l0 + msg_cnt - m0), 32'h0);

    // R3 and R10 exact timing on the rejected path
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'h101 | (32'd9 << 2));
    @(negedge clk);
    chk("R10 pulse due", {31'b0, irq_legacy}, 32'h1);
    chk("R10 vector during pulse", {26'b0, irq_vec}, 32'd9);
    @(negedge clk);
    chk("R10 pulse over", {31'b0, irq_legacy}, 32'h0);
    chk("R10 vector idle", {26'b0, irq_vec}, 32'h0);
    rd(5'h04, d); chk("R3 command self-clears", d, 32'h0);
    rd(5'h08, d); chk("R3 rejected status", d, 32'h0C2);

    // R3 status clear on new command, busy ignore
    wr(5'h10, BASE + 32'(50 * 4));
    wr(5'h14, 32'h20);
    a0 = acc_cnt;
    wr(5'h04, 32'h200);
    rd(5'h08, d); chk("R3 status cleared by command", d, 32'h0);
    wr(5'h04, 32'h100);
    rd(5'h04, d); chk("R3 busy command kept", d, 32'h200);
    for (int k = 0; k < 2000; k++) begin
      rd(5'h04, d);
      if (d == 0) break;
    end
    @(negedge clk);
    rd(5'h08, st);
    chk("R3 busy write ignored", st, 32'h004);
    chk("R3 busy write no extra traffic", 32'(acc_cnt - a0), 32'h8);

    chk("R10 pulse width", 32'(width_err), 32'h0);
    chk("R11 aligned in-range addresses", 32'(addr_err), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule